// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is a single high-speed DMA channel. Software programs a memory (source) address, a destination address, a transfer count and a control word through a halfword register port. Each accepted transfer request then drives a simple memory bus master port with addresses and read/write strobes. After each unit moves, the channel steps its working addresses by the programmed address-control code and the unit size, and it decrements its working counter. When the counter reaches zero it gives a one-cycle done pulse.

In dual-address mode each unit is a read at the source followed by a write at the destination, and the read data is carried over to the write. In single-address mode each unit is one memory cycle. A direction bit picks whether that cycle reads or writes memory. A peripheral acknowledge is held for the length of the cycle so that a peripheral can supply or take the data. Three transfer modes set how much one request moves: single moves one unit, successive runs to the end of the count, and block moves one block.

Writing the control word with the enable bit set copies the programmed values into separate working registers one cycle later. Software therefore always reads back the values it programmed.

Top module: `dma_chan_engine`

## Requirements
- R1: Dual-address mode (control bit 0 = 1). Each unit is a memory read at the source working address followed by a memory write at the destination working address. The write carries the data returned by that read. The direction bit is ignored in this mode.
- R2: Single-address mode (control bit 0 = 0). Each unit is one memory cycle at the memory (source) working address. It is a write when control bit 1 = 1 and a read when control bit 1 = 0. `per_ack` is high for the whole cycle, and the destination address is never driven.
- R3: After each unit the 28-bit working address changes according to its 2-bit code: 2'b11 increments, 2'b10 increments (and reloads at block end, see R6), 2'b01 decrements, 2'b00 holds. The step is 1 when control bit 2 = 0 (byte) and 2 when it is 1 (halfword). The address wraps modulo 2^28. The source code is in control bits 4:3 and the destination code in bits 6:5.
- R4: Single transfer mode (control bits 8:7 = 2'b00). Each request moves one unit. The 24-bit count is {count-high[7:0], count-low[15:0]}.
- R5: Successive mode (control bits 8:7 = 2'b01). One request moves units until the 24-bit count reaches zero.
- R6: Block mode (control bits 8:7 = 2'b10). Count-low bits 7:0 give the block length and count-high bits 7:0 give the number of blocks. Each request moves one whole block. At each block end, any address whose code is 2'b10 is reloaded from its programmed value.
- R7: When the count reaches zero, `done` pulses high for one cycle and the end flag (control read bit 15) is set. While the flag is set, requests are ignored. Any write to the control register clears the flag.
- R8: The register indices are 0 control, 1 count-low, 2 count-high, 3 source-low, 4 source-high, 5 destination-low and 6 destination-high. Reserved bits read as 0 and ignore writes (address-high keeps bits 11:0, count-high keeps bits 7:0). Programmed values read back unchanged after a transfer. The control register resets to 0.
- R9: Requests are ignored while the enable bit (control bit 9) is 0. A control write with enable = 1 reloads the working address and count registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| xfer_req | input | 1 | Transfer request pulse |
| per_ack | output | 1 | Peripheral acknowledge during a single-address cycle |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_half | output | 1 | Unit size is a halfword |
| mem_addr | output | 28 | Memory address |
| mem_wdata | output | 16 | Write data in dual-address mode |
| mem_rdata | input | 16 | Read data |
| mem_ack | input | 1 | Memory cycle completes at this edge |
| done | output | 1 | One-cycle terminal count pulse |

## Verification
The hardest case to reach is a block boundary in block mode. There the source address, coded for increment-with-reload, must jump back to its programmed start, while the destination address keeps incrementing from where it stopped. The stimulus programs two halfword blocks of three units and issues two requests. The last read and last write addresses are then compared with values worked out by hand. A second corner is the request that arrives after terminal count. It is reached by issuing one request more than the count allows, which must produce no bus cycle, and then by a control rewrite that must bring the channel back.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int ADDR_W_DEF = 28;
    localparam int CNT_W_DEF  = 24;
    localparam int BLK_W_DEF  = 8;
    localparam int REG_W      = 16;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_CNTLO = 3'd1;
    localparam logic [2:0] RA_CNTHI = 3'd2;
    localparam logic [2:0] RA_SRCLO = 3'd3;
    localparam logic [2:0] RA_SRCHI = 3'd4;
    localparam logic [2:0] RA_DSTLO = 3'd5;
    localparam logic [2:0] RA_DSTHI = 3'd6;

    typedef enum logic [1:0] {
        ACTL_FIXED      = 2'b00,
        ACTL_DEC        = 2'b01,
        ACTL_INC_RELOAD = 2'b10,
        ACTL_INC        = 2'b11
    } actl_e;

    typedef enum logic [1:0] {
        XM_SINGLE = 2'b00,
        XM_SUCC   = 2'b01,
        XM_BLOCK  = 2'b10,
        XM_RSVD   = 2'b11
    } xmode_e;

    // packed MSB first: enable is bit 9, dual is bit 0
    typedef struct packed {
        logic   enable;
        xmode_e xmode;
        actl_e  dst_ctl;
        actl_e  src_ctl;
        logic   half;
        logic   dir_wr;
        logic   dual;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RD   = 2'b01,
        ST_WR   = 2'b10,
        ST_SGL  = 2'b11
    } st_e;

    // signed address delta for one unit
    function automatic logic [2:0] addr_delta(actl_e ctl, logic half);
        logic [2:0] mag;
        mag = half ? 3'd2 : 3'd1;
        case (ctl)
            ACTL_FIXED: return 3'd0;
            ACTL_DEC:   return 3'd0 - mag;
            default:    return mag;
        endcase
    endfunction

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int CNT_W  = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              end_flag,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  cnt_prog,
    output logic [ADDR_W-1:0] src_prog,
    output logic [ADDR_W-1:0] dst_prog,
    output logic              load,
    output logic              clr_end
);
    localparam int HI_A = ADDR_W - REG_W;
    localparam int HI_C = CNT_W - REG_W;

    logic [REG_W-1:0] src_lo, dst_lo, cnt_lo;
    logic [HI_A-1:0]  src_hi, dst_hi;
    logic [HI_C-1:0]  cnt_hi;
    logic             ctrl_wr;

    assign ctrl_wr = we && (addr == RA_CTRL);
    assign clr_end = ctrl_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            load <= 1'b0;
        end else begin
            load <= ctrl_wr && wdata[CTRL_W-1];
            if (ctrl_wr) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    // address and count fields have no defined reset value
    always_ff @(posedge clk) begin
        if (we) begin
            case (addr)
                RA_CNTLO: cnt_lo <= wdata;
                RA_CNTHI: cnt_hi <= wdata[HI_C-1:0];
                RA_SRCLO: src_lo <= wdata;
                RA_SRCHI: src_hi <= wdata[HI_A-1:0];
                RA_DSTLO: dst_lo <= wdata;
                RA_DSTHI: dst_hi <= wdata[HI_A-1:0];
                default: ;
            endcase
        end
    end

    assign cnt_prog = {cnt_hi, cnt_lo};
    assign src_prog = {src_hi, src_lo};
    assign dst_prog = {dst_hi, dst_lo};

    always_comb begin
        case (addr)
            RA_CTRL:  rdata = {end_flag, {(REG_W-1-CTRL_W){1'b0}}, ctrl};
            RA_CNTLO: rdata = cnt_lo;
            RA_CNTHI: rdata = {{(REG_W-HI_C){1'b0}}, cnt_hi};
            RA_SRCLO: rdata = src_lo;
            RA_SRCHI: rdata = {{(REG_W-HI_A){1'b0}}, src_hi};
            RA_DSTLO: rdata = dst_lo;
            RA_DSTHI: rdata = {{(REG_W-HI_A){1'b0}}, dst_hi};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmach_addr_unit.sv
module dmach_addr_unit
    import dmach_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              load,
    input  logic              step,
    input  logic              blk_end,
    input  actl_e             ctl,
    input  logic              half,
    input  logic [ADDR_W-1:0] prog,
    output logic [ADDR_W-1:0] addr
);
    logic [2:0]        delta;
    logic [ADDR_W-1:0] delta_x;

    assign delta   = addr_delta(ctl, half);
    assign delta_x = {{(ADDR_W-3){delta[2]}}, delta};

    always_ff @(posedge clk) begin
        if (load)
            addr <= prog;
        else if (step)
            addr <= (blk_end && ctl == ACTL_INC_RELOAD) ? prog : addr + delta_x;
    end
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
    import dmach_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int BLK_W = BLK_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] cnt_prog,
    input  logic             load,
    input  logic             clr_end,
    input  logic             xfer_req,
    input  logic             mem_ack,
    input  logic [REG_W-1:0] mem_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic             use_dst,
    output logic             per_ack,
    output logic             unit_done,
    output logic             blk_end,
    output logic             done,
    output logic             end_flag,
    output logic [REG_W-1:0] data_q
);
    localparam int BCNT_LSB = CNT_W - BLK_W;

    st_e              state;
    st_e              first_ph;
    logic [CNT_W-1:0] wcnt;
    logic [BLK_W-1:0] blk_left;
    logic             is_block, is_succ, go, last_unit, cnt_dec, terminal, stop;

    assign is_block  = (ctrl.xmode == XM_BLOCK);
    assign is_succ   = (ctrl.xmode == XM_SUCC);
    assign first_ph  = ctrl.dual ? ST_RD : ST_SGL;
    assign go        = (state == ST_IDLE) && ctrl.enable && !end_flag && xfer_req && !load;
    assign unit_done = mem_ack && (state == ST_WR || state == ST_SGL);
    assign last_unit = (blk_left == BLK_W'(1));
    assign cnt_dec   = unit_done && (!is_block || last_unit);
    assign blk_end   = unit_done && is_block && last_unit;
    assign terminal  = cnt_dec && (wcnt == CNT_W'(1));
    assign stop      = cnt_dec && (!is_succ || terminal);

    assign mem_req = (state != ST_IDLE);
    assign mem_we  = (state == ST_WR) || (state == ST_SGL && ctrl.dir_wr);
    assign use_dst = (state == ST_WR);
    assign per_ack = (state == ST_SGL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            end_flag <= 1'b0;
            wcnt     <= '0;
            blk_left <= '0;
            data_q   <= '0;
        end else begin
            done <= terminal;
            if (terminal)     end_flag <= 1'b1;
            else if (clr_end) end_flag <= 1'b0;

            if (load) begin
                state <= ST_IDLE;
                wcnt  <= is_block ? CNT_W'(cnt_prog[CNT_W-1:BCNT_LSB]) : cnt_prog;
            end else begin
                case (state)
                    ST_IDLE: if (go) begin
                        state    <= first_ph;
                        blk_left <= cnt_prog[BLK_W-1:0];
                    end
                    ST_RD: if (mem_ack) begin
                        data_q <= mem_rdata;
                        state  <= ST_WR;
                    end
                    default: if (mem_ack) begin
                        blk_left <= blk_left - BLK_W'(1);
                        if (cnt_dec) wcnt <= wcnt - CNT_W'(1);
                        state <= stop ? ST_IDLE : first_ph;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dmach_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int CNT_W  = CNT_W_DEF,
    parameter int BLK_W  = BLK_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              xfer_req,
    output logic              per_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_half,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [REG_W-1:0]  mem_wdata,
    input  logic [REG_W-1:0]  mem_rdata,
    input  logic              mem_ack,
    output logic              done
);
    localparam int N_ADDR = 2;

    ctrl_t             ctrl;
    logic [CNT_W-1:0]  cnt_prog;
    logic [ADDR_W-1:0] src_prog, dst_prog;
    logic              load, clr_end, end_flag, unit_done, blk_end, use_dst;
    logic [ADDR_W-1:0] prog_a  [N_ADDR];
    logic [ADDR_W-1:0] waddr   [N_ADDR];
    actl_e             ctl_a   [N_ADDR];
    logic              step_a  [N_ADDR];

    dmach_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .end_flag(end_flag), .ctrl(ctrl), .cnt_prog(cnt_prog),
        .src_prog(src_prog), .dst_prog(dst_prog), .load(load), .clr_end(clr_end)
    );

    dmach_seq #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_seq (
        .clk(clk), .rst(rst), .ctrl(ctrl), .cnt_prog(cnt_prog), .load(load),
        .clr_end(clr_end), .xfer_req(xfer_req), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .use_dst(use_dst), .per_ack(per_ack), .unit_done(unit_done),
        .blk_end(blk_end), .done(done), .end_flag(end_flag), .data_q(mem_wdata)
    );

    assign prog_a[0] = src_prog;
    assign prog_a[1] = dst_prog;
    assign ctl_a[0]  = ctrl.src_ctl;
    assign ctl_a[1]  = ctrl.dst_ctl;

    // index 0: source/memory address, index 1: destination (dual mode only)
    for (genvar i = 0; i < N_ADDR; i++) begin : g_addr
        assign step_a[i] = unit_done && (i == 0 || ctrl.dual);
        dmach_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
            .clk(clk), .load(load), .step(step_a[i]), .blk_end(blk_end),
            .ctl(ctl_a[i]), .half(ctrl.half), .prog(prog_a[i]), .addr(waddr[i])
        );
    end

    assign mem_addr = use_dst ? waddr[1] : waddr[0];
    assign mem_half = ctrl.half;
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
    parameter int ADDR_W = 28
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic              per_ack,
    input logic              done,
    input logic              end_flag,
    input logic              load,
    input logic              unit_done,
    input logic [1:0]        src_ctl,
    input logic              half,
    input logic [ADDR_W-1:0] src_addr
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_END_BLOCKS_BUS: assert property (@(posedge clk) disable iff (rst)
        (end_flag && !load) |=> !mem_req); // R7

    AST_PACK_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        per_ack |-> mem_req); // R2

    AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        !mem_req |-> !mem_we); // R2

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !per_ack) |-> $past(mem_req && !mem_we)); // R1

    AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (unit_done && src_ctl == 2'b00 && !load) |=> $stable(src_addr)); // R3

    AST_BYTE_INC: assert property (@(posedge clk) disable iff (rst)
        (unit_done && src_ctl == 2'b11 && !half && !load)
        |=> src_addr == $past(src_addr) + ADDR_W'(1)); // R3
endmodule

bind dma_chan_engine dmach_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .per_ack(per_ack),
    .done(done), .end_flag(end_flag), .load(load), .unit_done(unit_done),
    .src_ctl(ctrl.src_ctl), .half(ctrl.half), .src_addr(waddr[0])
);

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        xfer_req = 1'b0;
    logic        per_ack, mem_req, mem_we, mem_half, done;
    logic [27:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        mem_ack = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    dma_chan_engine u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
        .per_ack(per_ack), .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .done(done)
    );

    function automatic logic [15:0] mem_model(input logic [27:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction
    assign mem_rdata = mem_model(mem_addr);

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // bus monitor and one-cycle memory responder
    int          m_rd, m_wr, m_pack, m_done, m_derr;
    logic [27:0] m_lrd, m_lwr;
    initial begin
        m_rd = 0; m_wr = 0; m_pack = 0; m_done = 0; m_derr = 0;
        m_lrd = '0; m_lwr = '0;
    end

    always @(negedge clk) begin
        if (done) m_done++;
        if (mem_req) begin
            if (per_ack) m_pack++;
            if (mem_we) begin
                m_wr++;
                m_lwr = mem_addr;
                if (!per_ack && mem_wdata != mem_model(m_lrd)) m_derr++;
            end else begin
                m_rd++;
                m_lrd = mem_addr;
            end
            mem_ack = 1'b1;
        end else begin
            mem_ack = 1'b0;
        end
    end

    task automatic mon_clear();
        m_rd = 0; m_wr = 0; m_pack = 0; m_done = 0; m_derr = 0;
        m_lrd = '0; m_lwr = '0;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic request(input int wait_cyc);
        @(negedge clk);
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        repeat (wait_cyc) @(negedge clk);
    endtask

    typedef struct packed {
        logic [15:0] ctrl;
        logic [23:0] cnt;
        logic [27:0] src;
        logic [27:0] dst;
        logic [3:0]  nreq;
        logic [7:0]  e_rd;
        logic [7:0]  e_wr;
        logic [27:0] e_lrd;
        logic [27:0] e_lwr;
        logic [7:0]  e_pack;
        logic [7:0]  e_done;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        // single-addr read, byte, inc, single mode, count 3, two requests
        '{16'h0218, 24'h000003, 28'h0001000, 28'h0000000, 4'd2, 8'd2, 8'd0, 28'h0001001, 28'h0000000, 8'd2, 8'd0},
        // single-addr write, halfword, dec, single mode, count 2, third request after end
        '{16'h020E, 24'h000002, 28'h0000002, 28'h0000000, 4'd3, 8'd0, 8'd2, 28'h0000000, 28'h0000000, 8'd2, 8'd1},
        // dual, byte, src inc wrapping at 2^28, dst fixed, successive, count 4
        '{16'h0299, 24'h000004, 28'hFFFFFFE, 28'h0ABCDEF, 4'd1, 8'd4, 8'd4, 28'h0000001, 28'h0ABCDEF, 8'd0, 8'd1},
        // dual, halfword, block len 3 x 2 blocks, src inc+reload, dst inc
        '{16'h0375, 24'h020003, 28'h0000100, 28'h0000800, 4'd2, 8'd6, 8'd6, 28'h0000104, 28'h000080A, 8'd0, 8'd1},
        // single-addr read, byte, fixed, block len 4 x 1 block
        '{16'h0300, 24'h010004, 28'h0003000, 28'h0000000, 4'd1, 8'd4, 8'd0, 28'h0003000, 28'h0000000, 8'd4, 8'd1},
        // dual with direction bit set (ignored), dec both, single mode, count 1
        '{16'h022B, 24'h000001, 28'h0000010, 28'h0000020, 4'd1, 8'd1, 8'd1, 28'h0000010, 28'h0000020, 8'd0, 8'd1}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R2 R3 R4";
            1: return "R2 R3 R4 R7";
            2: return "R1 R3 R5";
            3: return "R1 R3 R6";
            4: return "R2 R3 R6";
            default: return "R1 R3 R4";
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check("R7 done after reset", done, 0);
        check("R2 mem_req after reset", mem_req, 0);
        reg_read(3'd0, rv);
        check("R8 control reset value", rv, 16'h0000);

        // table walk
        for (int i = 0; i < NV; i++) begin
            reg_write(3'd1, VECS[i].cnt[15:0]);
            reg_write(3'd2, {8'h00, VECS[i].cnt[23:16]});
            reg_write(3'd3, VECS[i].src[15:0]);
            reg_write(3'd4, {4'h0, VECS[i].src[27:16]});
            reg_write(3'd5, VECS[i].dst[15:0]);
            reg_write(3'd6, {4'h0, VECS[i].dst[27:16]});
            reg_write(3'd0, VECS[i].ctrl);
            repeat (3) @(negedge clk);
            mon_clear();
            for (int k = 0; k < int'(VECS[i].nreq); k++) request(40);
            check({vec_tag(i), " reads"},      m_rd,   VECS[i].e_rd);
            check({vec_tag(i), " writes"},     m_wr,   VECS[i].e_wr);
            check({vec_tag(i), " last read"},  m_lrd,  VECS[i].e_lrd);
            check({vec_tag(i), " last write"}, m_lwr,  VECS[i].e_lwr);
            check({vec_tag(i), " per_ack"},    m_pack, VECS[i].e_pack);
            check({vec_tag(i), " done"},       m_done, VECS[i].e_done);
            check({vec_tag(i), " data copy"},  m_derr, 0);
        end

        // end flag visible, requests ignored while set
        reg_read(3'd0, rv);
        check("R7 end flag in control bit 15", rv, 16'h822B);
        reg_read(3'd3, rv);
        check("R8 source-low reads programmed value", rv, 16'h0010);
        reg_read(3'd5, rv);
        check("R8 destination-low reads programmed value", rv, 16'h0020);
        mon_clear();
        request(10);
        check("R7 request ignored at end", m_rd + m_wr, 0);

        // control rewrite clears the flag and restarts from programmed values
        reg_write(3'd0, 16'h022B);
        reg_read(3'd0, rv);
        check("R7 end flag cleared by control write", rv, 16'h022B);
        repeat (2) @(negedge clk);
        mon_clear();
        request(10);
        check("R9 reload restarts at programmed source", m_lrd, 28'h0000010);
        check("R9 reload then one unit", m_rd, 1);

        // reserved bits
        reg_write(3'd4, 16'hFFFF);
        reg_read(3'd4, rv);
        check("R8 source-high reserved bits", rv, 16'h0FFF);
        reg_write(3'd2, 16'hFFFF);
        reg_read(3'd2, rv);
        check("R8 count-high reserved bits", rv, 16'h00FF);

        // disabled channel
        reg_write(3'd1, 16'h0005);
        reg_write(3'd2, 16'h0000);
        reg_write(3'd0, 16'h0018);
        repeat (3) @(negedge clk);
        mon_clear();
        request(10);
        check("R9 request ignored while disabled", m_rd + m_wr, 0);
        check("R9 no done while disabled", m_done, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule